// File: doc/BRIEF.md
# I/O Cycle Routing Decoder

This block sits beside the host I/O path and decides, for every I/O cycle, whether the cycle belongs to the internal ISA bus, to the LPC interface, or to no target. It compares the cycle address against a handful of fixed legacy peripheral windows and up to ten software-placed windows. For the lowest-numbered matching window, it combines that window's enable bit with a global default-mapping bit to pick the target. The default-mapping bit also decides the fate of cycles that hit no window: they are dropped, or passed to LPC.

The same block holds the DMA request steering. Each DMA channel takes its request either from its own ISA request pin or from the one shared LPC request line, as its select bit says. All state sits in a small word-indexed register file. Writes land on the clock edge that samples the strobe. Reads are combinational.

Top module: `io_route_decoder`

## Requirements
- R1: After reset, every register reads zero: the routing word (index 0), the DMA select word (index 1) and every window word (index 2+k).
- R2: The routing word keeps bits 17:0 of the written data and reads bits 31:18 as zero. A write becomes visible only after the clock edge that samples `reg_wr`.
- R3: Fixed windows, listed as enable bit and claimed addresses: bit 10 claims 0x60 and 0x64; bit 11 claims 0x62 and 0x66; bit 12 claims 0x388–0x389; bit 13 claims 0x2E–0x2F; bit 14 claims 0x4E–0x4F; bit 17 claims 0x70–0x73. Neighbouring addresses such as 0x65 are not claimed.
- R4: A claimed cycle goes to LPC when its enable bit differs from default bit 16. It goes to ISA when the two bits are equal.
- R5: A cycle claimed by no window goes to no target when bit 16 is 0, and to LPC when bit 16 is 1.
- R6: Window k (0..9) is configured at index 2+k, with the base in bits 15:0 and an ignore mask in bits 31:16. An address matches window k when it equals the base in every bit the mask leaves clear. Enable bit k of the routing word then applies the rule of R4.
- R7: When several windows match, the lowest-numbered matching bit alone decides the route.
- R8: Bit 15 reads back as written and has no effect on routing.
- R9: DMA select bits 2:0 sit at index 1. Channel i outputs its ISA request when its bit is 0, and the shared LPC request when its bit is 1.
- R10: `io_tgt` is one-hot while `io_valid` is high: bit 0 means ISA, bit 1 means LPC, bit 2 means no target. It is all zeros while `io_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` |
| io_valid | input | 1 | I/O cycle present |
| io_addr | input | 16 | I/O cycle address |
| io_tgt | output | 3 | One-hot target {none, LPC, ISA} |
| drq_isa | input | 3 | Per-channel ISA DMA requests |
| drq_lpc | input | 1 | Shared LPC DMA request |
| drq_out | output | 3 | Steered DMA requests |

## Verification
Two functions can act in the same cycle. A routing lookup can fall in the cycle where a write to the routing word is pending. The bench issues a lookup in that cycle and expects the route set by the old value, then repeats the lookup after the edge and expects the new route. The second collision is an address that falls inside both a programmable window and a fixed window. With such an address, the bench flips which of the two enable bits is set and judges the result against the lowest-numbered bit only.

// File: rtl/io_route_pkg.sv
package io_route_pkg;
   localparam int EN_W      = 18;
   localparam int DFLT_BIT  = 16;
   localparam int ROMEN_BIT = 15;
   localparam int MAX_PROG  = 10;

   localparam logic [2:0] TGT_OFF  = 3'b000;
   localparam logic [2:0] TGT_ISA  = 3'b001;
   localparam logic [2:0] TGT_LPC  = 3'b010;
   localparam logic [2:0] TGT_NONE = 3'b100;

   typedef struct packed {
      logic [15:0] lo;
      logic [15:0] hi;
   } span_t;

   // fixed windows, indexed by routing-word bit
   function automatic span_t fixed_span_a(input int b);
      span_t s;
      case (b)
         10: s = '{lo: 16'h0060, hi: 16'h0060};
         11: s = '{lo: 16'h0062, hi: 16'h0062};
         12: s = '{lo: 16'h0388, hi: 16'h0389};
         13: s = '{lo: 16'h002E, hi: 16'h002F};
         14: s = '{lo: 16'h004E, hi: 16'h004F};
         17: s = '{lo: 16'h0070, hi: 16'h0073};
         default: s = '{lo: 16'hFFFF, hi: 16'h0000};
      endcase
      return s;
   endfunction

   // second single-port claim of the split windows
   function automatic span_t fixed_span_b(input int b);
      span_t s;
      case (b)
         10: s = '{lo: 16'h0064, hi: 16'h0064};
         11: s = '{lo: 16'h0066, hi: 16'h0066};
         default: s = '{lo: 16'hFFFF, hi: 16'h0000};
      endcase
      return s;
   endfunction

   function automatic bit is_fixed(input int b);
      return (b >= 10 && b <= 14) || b == 17;
   endfunction
endpackage

// File: rtl/io_route_regs.sv
module io_route_regs
   import io_route_pkg::*;
#(
   parameter int NPROG = 10,
   parameter int NDRQ  = 3,
   parameter int AW    = 16,
   parameter int IDX_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [IDX_W-1:0]           idx,
   input  logic [31:0]                wdata,
   output logic [31:0]                rdata,
   output logic [EN_W-1:0]            route_en,
   output logic [NDRQ-1:0]            dma_sel,
   output logic [NPROG-1:0][AW-1:0]   base,
   output logic [NPROG-1:0][AW-1:0]   mask
);
   localparam logic [IDX_W-1:0] IDX_ROUTE = IDX_W'(0);
   localparam logic [IDX_W-1:0] IDX_DMA   = IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_en <= '0;
         dma_sel  <= '0;
         base     <= '0;
         mask     <= '0;
      end else if (wr) begin
         if (idx == IDX_ROUTE) route_en <= wdata[EN_W-1:0];
         if (idx == IDX_DMA)   dma_sel  <= wdata[NDRQ-1:0];
         for (int k = 0; k < NPROG; k++) begin
            if (idx == IDX_W'(2 + k)) begin
               base[k] <= wdata[AW-1:0];
               mask[k] <= wdata[16 +: AW];
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (idx == IDX_ROUTE) rdata[EN_W-1:0] = route_en;
      else if (idx == IDX_DMA) rdata[NDRQ-1:0] = dma_sel;
      else begin
         for (int k = 0; k < NPROG; k++) begin
            if (idx == IDX_W'(2 + k)) rdata = {16'(mask[k]), 16'(base[k])};
         end
      end
   end

   a_r2_route_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == IDX_ROUTE) |=> route_en == $past(wdata[EN_W-1:0]));
   a_r9_dma_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == IDX_DMA) |=> dma_sel == $past(wdata[NDRQ-1:0]));
   a_r2_route_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && idx == IDX_ROUTE) |=> $stable(route_en));
endmodule

// File: rtl/io_route_match.sv
module io_route_match
   import io_route_pkg::*;
#(
   parameter int NPROG = 10,
   parameter int AW    = 16
) (
   input  logic [AW-1:0]              addr,
   input  logic [NPROG-1:0][AW-1:0]   base,
   input  logic [NPROG-1:0][AW-1:0]   mask,
   output logic [EN_W-1:0]            hit
);
   for (genvar b = 0; b < EN_W; b++) begin : g_bit
      if (b < NPROG) begin : g_prog
         assign hit[b] = ((addr ^ base[b]) & ~mask[b]) == '0;
      end else if (is_fixed(b)) begin : g_fixed
         localparam span_t SA = fixed_span_a(b);
         localparam span_t SB = fixed_span_b(b);
         logic [15:0] a16;
         assign a16 = 16'(addr);
         assign hit[b] = (a16 >= SA.lo && a16 <= SA.hi) ||
                         (a16 >= SB.lo && a16 <= SB.hi);
      end else begin : g_none
         assign hit[b] = 1'b0;
      end
   end
endmodule

// File: rtl/io_route_dma.sv
module io_route_dma #(
   parameter int NDRQ = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NDRQ-1:0] sel,
   input  logic [NDRQ-1:0] drq_isa,
   input  logic            drq_lpc,
   output logic [NDRQ-1:0] drq_out
);
   for (genvar i = 0; i < NDRQ; i++) begin : g_ch
      assign drq_out[i] = sel[i] ? drq_lpc : drq_isa[i];

      a_r9_isa_path: assert property (@(posedge clk) disable iff (!rst_n)
         !sel[i] |-> drq_out[i] == drq_isa[i]);
      a_r9_lpc_path: assert property (@(posedge clk) disable iff (!rst_n)
         sel[i] |-> drq_out[i] == drq_lpc);
   end
endmodule

// File: rtl/io_route_decoder.sv
module io_route_decoder
   import io_route_pkg::*;
#(
   parameter int NPROG = 10,
   parameter int NDRQ  = 3,
   parameter int AW    = 16,
   localparam int IDX_W = $clog2(2 + NPROG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [IDX_W-1:0] reg_idx,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             io_valid,
   input  logic [AW-1:0]    io_addr,
   output logic [2:0]       io_tgt,
   input  logic [NDRQ-1:0]  drq_isa,
   input  logic             drq_lpc,
   output logic [NDRQ-1:0]  drq_out
);
   if (NPROG < 1 || NPROG > MAX_PROG) begin : g_bad_nprog
      $error("NPROG must lie in 1..10");
   end
   if (NDRQ < 1 || NDRQ > 8) begin : g_bad_ndrq
      $error("NDRQ must lie in 1..8");
   end
   if (AW < 10 || AW > 16) begin : g_bad_aw
      $error("AW must lie in 10..16");
   end

   logic [EN_W-1:0]          route_en;
   logic [NDRQ-1:0]          dma_sel;
   logic [NPROG-1:0][AW-1:0] base;
   logic [NPROG-1:0][AW-1:0] mask;
   logic [EN_W-1:0]          hit;

   io_route_regs #(.NPROG(NPROG), .NDRQ(NDRQ), .AW(AW), .IDX_W(IDX_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
      .rdata(reg_rdata), .route_en(route_en), .dma_sel(dma_sel),
      .base(base), .mask(mask)
   );

   io_route_match #(.NPROG(NPROG), .AW(AW)) i_match (
      .addr(io_addr), .base(base), .mask(mask), .hit(hit)
   );

   io_route_dma #(.NDRQ(NDRQ)) i_dma (
      .clk(clk), .rst_n(rst_n), .sel(dma_sel), .drq_isa(drq_isa),
      .drq_lpc(drq_lpc), .drq_out(drq_out)
   );

   // lowest matching bit wins
   logic claimed;
   logic win_en;
   always_comb begin
      claimed = 1'b0;
      win_en  = 1'b0;
      for (int b = EN_W - 1; b >= 0; b--) begin
         if (hit[b]) begin
            claimed = 1'b1;
            win_en  = route_en[b];
         end
      end
   end

   logic dflt;
   assign dflt = route_en[DFLT_BIT];

   always_comb begin
      if (!io_valid)             io_tgt = TGT_OFF;
      else if (claimed)          io_tgt = (win_en ^ dflt) ? TGT_LPC : TGT_ISA;
      else if (dflt)             io_tgt = TGT_LPC;
      else                       io_tgt = TGT_NONE;
   end

   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid |-> $onehot(io_tgt));
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !io_valid |-> io_tgt == 3'b000);
   a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && hit == '0 && !dflt) |-> io_tgt == TGT_NONE);
   a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && hit == '0 && dflt) |-> io_tgt == TGT_LPC);
endmodule

// File: tb/test_io_route_decoder.sv
module test_io_route_decoder;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] T_OFF = 3'b000, T_ISA = 3'b001, T_LPC = 3'b010, T_NONE = 3'b100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        io_valid = 1'b0;
   logic [15:0] io_addr = '0;
   logic [2:0]  io_tgt;
   logic [2:0]  drq_isa = '0;
   logic        drq_lpc = 1'b0;
   logic [2:0]  drq_out;

   int checks = 0;
   int fails  = 0;
   logic [2:0] exp_q[$];
   string      tag_q[$];
   logic [15:0] adr_q[$];
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   io_route_decoder i_io_route_decoder (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_valid(io_valid),
      .io_addr(io_addr), .io_tgt(io_tgt), .drq_isa(drq_isa),
      .drq_lpc(drq_lpc), .drq_out(drq_out)
   );

   // monitor: compare one queued lookup per falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string t;
         logic [15:0] a;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = adr_q.pop_front();
         checks++;
         if (io_tgt !== e) begin
            fails++;
            $display("FAIL %s addr=%h tgt actual=%b expected=%b", t, a, io_tgt, e);
         end
      end
   end

   task automatic look(input logic [15:0] a, input logic [2:0] e, input string t);
      @(posedge clk); #1;
      io_valid = 1'b1;
      io_addr  = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      adr_q.push_back(a);
   endtask

   task automatic flush();
      @(posedge clk); #1;
      io_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic wreg(input logic [3:0] i, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic chk_rd(input logic [3:0] i, input logic [31:0] e, input string t);
      reg_idx = i;
      #1;
      checks++;
      if (reg_rdata !== e) begin
         fails++;
         $display("FAIL %s rdata idx=%0d actual=%h expected=%h", t, i, reg_rdata, e);
      end
   endtask

   task automatic chk_drq(input logic [2:0] e, input string t);
      #1;
      checks++;
      if (drq_out !== e) begin
         fails++;
         $display("FAIL %s drq_out actual=%b expected=%b", t, drq_out, e);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk_rd(0, 32'h0, "R1 route word");
      chk_rd(1, 32'h0, "R1 dma word");
      chk_rd(4, 32'h0, "R1 window word");
      io_addr = 16'h0070; #1;
      checks++;
      if (io_tgt !== T_OFF) begin
         fails++;
         $display("FAIL R10 idle actual=%b expected=%b", io_tgt, T_OFF);
      end

      // place the ten windows at 0x1000+k*0x100, 8 ports each
      for (int k = 0; k < 10; k++) wreg(4'(2 + k), {16'h0007, 16'(16'h1000 + k * 16'h100)});
      @(negedge clk);
      chk_rd(5, 32'h0007_1300, "R6 window readback");

      look(16'h0070, T_ISA,  "R3 R4 rtc x0 d0");
      look(16'h0500, T_NONE, "R5 unclaimed d0");
      look(16'h1003, T_ISA,  "R6 window0 x0 d0");
      look(16'h0388, T_ISA,  "R3 adlib x0 d0");
      flush();

      // enables for bits 17 and 10; lookup in the write cycle sees old value
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_idx = 0; reg_wdata = (32'h1 << 17) | (32'h1 << 10);
      io_valid = 1'b1; io_addr = 16'h0071;
      exp_q.push_back(T_ISA); tag_q.push_back("R2 write not yet visible"); adr_q.push_back(16'h0071);
      @(posedge clk); #1;
      reg_wr = 1'b0;
      io_addr = 16'h0071;
      exp_q.push_back(T_LPC); tag_q.push_back("R2 write visible after edge"); adr_q.push_back(16'h0071);
      look(16'h0064, T_LPC,  "R3 R4 kbc 0x64 x1 d0");
      look(16'h0060, T_LPC,  "R3 kbc 0x60 x1 d0");
      look(16'h0062, T_ISA,  "R3 acpi 0x62 x0 d0");
      look(16'h0065, T_NONE, "R3 0x65 unclaimed");
      look(16'h0074, T_NONE, "R3 0x74 unclaimed");
      flush();

      // default bit set
      wreg(0, (32'h1 << 17) | (32'h1 << 16));
      look(16'h0072, T_ISA, "R4 rtc x1 d1");
      look(16'h002E, T_LPC, "R4 superio x0 d1");
      look(16'h004F, T_LPC, "R4 alt superio x0 d1");
      look(16'h0500, T_LPC, "R5 unclaimed d1");
      flush();

      // programmable window 3
      wreg(0, 32'h1 << 3);
      look(16'h1307, T_LPC,  "R6 window3 top x1");
      look(16'h1300, T_LPC,  "R6 window3 base x1");
      look(16'h1308, T_NONE, "R6 beyond window3");
      look(16'h1203, T_ISA,  "R6 window2 x0");
      flush();

      // overlap: window 2 covers 0x60..0x67
      wreg(4, {16'h0007, 16'h0060});
      wreg(0, 32'h1 << 2);
      look(16'h0064, T_LPC, "R7 window2 bit wins over kbc");
      flush();
      wreg(0, 32'h1 << 10);
      look(16'h0064, T_ISA, "R7 kbc bit ignored under window2");
      flush();
      wreg(0, 32'h1 << 11);
      look(16'h0066, T_ISA, "R7 acpi bit ignored under window2");
      flush();
      wreg(4, {16'h0007, 16'h1200});

      // rom enable bit
      wreg(0, 32'h1 << 15);
      @(negedge clk);
      chk_rd(0, 32'h0000_8000, "R8 rom bit readback");
      look(16'h0070, T_ISA,  "R8 rom bit no effect claimed");
      look(16'h0500, T_NONE, "R8 rom bit no effect unclaimed");
      flush();

      // reserved bits
      wreg(0, 32'hFFFF_FFFF);
      @(negedge clk);
      chk_rd(0, 32'h0003_FFFF, "R2 reserved read zero");
      look(16'h0070, T_ISA, "R4 rtc x1 d1 all set");
      look(16'h0500, T_LPC, "R5 unclaimed d1 all set");
      flush();

      // DMA steering
      wreg(1, 32'hFFFF_FFF5);
      @(negedge clk);
      chk_rd(1, 32'h0000_0005, "R9 select readback");
      drq_isa = 3'b010; drq_lpc = 1'b1;
      chk_drq(3'b111, "R9 mix lpc=1");
      drq_lpc = 1'b0;
      chk_drq(3'b010, "R9 mix lpc=0");
      drq_isa = 3'b000; drq_lpc = 1'b1;
      chk_drq(3'b101, "R9 lpc only");
      drq_isa = 3'b111; drq_lpc = 1'b0;
      chk_drq(3'b010, "R9 isa only");

      // valid low
      io_valid = 1'b0; io_addr = 16'h0070; #1;
      checks++;
      if (io_tgt !== T_OFF) begin
         fails++;
         $display("FAIL R10 valid low actual=%b expected=%b", io_tgt, T_OFF);
      end
      repeat (2) @(posedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule